// File: doc/BRIEF.md
# Event pattern RAM sequencer

This block replays stored test events on demand. A 4096-word memory of 28-bit words is split into four 1024-word buffers. Each word holds 23 data bits and 5 control bits. A host fills the memory through an address counter and can read it back while transmission is off. Once transmission is on, each incoming trigger carries a 2-bit buffer number. The sequencer takes the next queued trigger, reads one event from that buffer and writes the event's words, control bits included, into an output FIFO. A downstream pacer drains that FIFO and handles delays and strobe timing.

All buffers share one event-offset counter. The buffer number supplies only the top two read-address bits, so events must start at the same offset in every buffer. The offset moves on by one event per trigger. A word that carries both end-of-event and terminator sends the offset back to the first event.

Top module: `evtpat_seq`

## Requirements
- R1: After reset, transmission is off, the output FIFO is empty (out_valid low), host_rdata is zero and the event offset is zero.
- R2: Host op codes are 0 = write, 1 = clear address, 2 = advance address and 3 = read. A write stores host_wdata at the address counter and then increments it. Clear sets the counter to 0. Advance increments the counter without writing.
- R3: While transmission is off, a read op makes host_rdata show the word at the address counter two rising edges after the op is sampled. While transmission is on, a read op leaves host_rdata unchanged.
- R4: Triggers are queued only while transmission is on. A trigger presented while it is off is dropped and never produces output. The sequencer takes a queued trigger only when the queue is not empty.
- R5: Each event is read from address buffer*1024 + offset, using the buffer number of its trigger. Events leave in trigger order.
- R6: Word layout: bits 22..0 data, bit 23 delay, bit 24 gap, bit 25 empty event, bit 26 end of event, bit 27 terminator. Words enter the output FIFO unchanged. An event's words are written up to and including its end-of-event word.
- R7: After each event the offset points to the word after its end-of-event word. The exception is an end-of-event word with the terminator set: that word resets the offset to 0. This holds whichever buffer was used.
- R8: An empty-event word is written to the output FIFO on its own. The rest of that event, up to and including its end-of-event word, is skipped without being written.
- R9: While the output FIFO is full the sequencer stalls. No word is lost or duplicated.
- R10: out_valid is high exactly when the output FIFO holds a word. out_word shows the oldest word, and out_rd removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| trig_valid | input | 1 | Trigger pulse |
| trig_buf | input | 2 | Buffer number of the trigger |
| host_op_valid | input | 1 | Host operation strobe |
| host_op | input | 2 | Host operation code |
| host_wdata | input | 28 | Word to store on a write op |
| host_rdata | output | 28 | Last word read back |
| en_we | input | 1 | Write strobe for the transmit-enable bit |
| en_wdata | input | 1 | New transmit-enable value |
| tx_en | output | 1 | Current transmit-enable bit |
| out_rd | input | 1 | Pop the output FIFO |
| out_valid | output | 1 | Output FIFO not empty |
| out_word | output | 28 | Oldest word in the output FIFO |

## Verification
Two things can happen in the same cycle: the sequencer presents a word while the output FIFO is full, and the downstream side pops a word. The bench provokes this by queuing four triggers, twelve words in all, without popping, so the sequencer stalls. It then drains the FIFO one word per cycle. Each freed slot is refilled while pops continue. The bench judges the result by comparing every drained word, in order, against the words it predicts from its own copy of the pattern. It then confirms that the count is exact and that nothing extra appears afterwards.

// File: rtl/evtpat_pkg.sv
package evtpat_pkg;
  localparam int DATA_W   = 23;
  localparam int CTRL_W   = 5;
  localparam int WORD_W   = DATA_W + CTRL_W;
  localparam int BIT_DLY  = 23;
  localparam int BIT_GAP  = 24;
  localparam int BIT_EMPTY = 25;
  localparam int BIT_EOE  = 26;
  localparam int BIT_TERM = 27;

  typedef enum logic [1:0] {
    HOST_WRITE    = 2'd0,
    HOST_ADDR_CLR = 2'd1,
    HOST_ADDR_INC = 2'd2,
    HOST_READ     = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    RD_IDLE  = 2'd0,
    RD_FETCH = 2'd1,
    RD_CHECK = 2'd2
  } rd_state_e;
endpackage

// File: rtl/evtpat_fifo.sv
module evtpat_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en_i,
  input  logic [W-1:0] wr_data_i,
  input  logic         rd_en_i,
  output logic [W-1:0] rd_data_o,
  output logic         empty_o,
  output logic         full_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     slot_q [DEPTH];
  logic [PTR_W-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             do_wr, do_rd;

  assign empty_o   = (cnt_q == '0);
  assign full_o    = (cnt_q == CNT_W'(DEPTH));
  assign do_wr     = wr_en_i && !full_o;
  assign do_rd     = rd_en_i && !empty_o;
  assign rd_data_o = slot_q[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_wr) wp_d = (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + PTR_W'(1);
    if (do_rd) rp_d = (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + PTR_W'(1);
    case ({do_wr, do_rd})
      2'b10:   cnt_d = cnt_q + CNT_W'(1);
      2'b01:   cnt_d = cnt_q - CNT_W'(1);
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_wr) slot_q[wp_q] <= wr_data_i;
  end

  // R10
  push_shows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (do_wr && !do_rd) |=> !empty_o);
endmodule

// File: rtl/evtpat_mem.sv
module evtpat_mem
  import evtpat_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_op_valid_i,
  input  logic [1:0]        host_op_i,
  input  logic [WORD_W-1:0] host_wdata_i,
  input  logic              rd_owner_i,
  input  logic [ADDR_W-1:0] rdr_addr_i,
  output logic [WORD_W-1:0] rd_word_o,
  output logic [WORD_W-1:0] host_rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] ram_q [DEPTH];
  logic [WORD_W-1:0] rd_word_q;
  logic [WORD_W-1:0] hrd_q, hrd_d;
  logic [ADDR_W-1:0] haddr_q, haddr_d;
  logic [ADDR_W-1:0] raddr;
  logic              rd_pend_q, rd_pend_d;
  logic              wr_hit;
  host_op_e          op;

  assign op        = host_op_e'(host_op_i);
  assign wr_hit    = host_op_valid_i && (op == HOST_WRITE);
  assign raddr     = rd_owner_i ? rdr_addr_i : haddr_q;
  assign rd_word_o = rd_word_q;
  assign host_rdata_o = hrd_q;

  always_comb begin
    haddr_d = haddr_q;
    if (host_op_valid_i) begin
      case (op)
        HOST_WRITE, HOST_ADDR_INC: haddr_d = haddr_q + ADDR_W'(1);
        HOST_ADDR_CLR:             haddr_d = '0;
        default:                   haddr_d = haddr_q;
      endcase
    end
    rd_pend_d = host_op_valid_i && (op == HOST_READ) && !rd_owner_i;
    hrd_d     = rd_pend_q ? rd_word_q : hrd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      haddr_q   <= '0;
      rd_pend_q <= 1'b0;
      hrd_q     <= '0;
    end else begin
      haddr_q   <= haddr_d;
      rd_pend_q <= rd_pend_d;
      hrd_q     <= hrd_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_hit) ram_q[haddr_q] <= host_wdata_i;
    rd_word_q <= ram_q[raddr];
  end
endmodule

// File: rtl/evtpat_reader.sv
module evtpat_reader
  import evtpat_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BUF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tx_en_i,
  input  logic              trig_empty_i,
  input  logic [BUF_W-1:0]  trig_buf_i,
  output logic              trig_pop_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [WORD_W-1:0] rd_word_i,
  input  logic              out_full_i,
  output logic              push_o,
  output logic [WORD_W-1:0] push_word_o,
  output logic              busy_o
);
  localparam int OFF_W = ADDR_W - BUF_W;

  rd_state_e        st_q, st_d;
  logic [BUF_W-1:0] buf_q, buf_d;
  logic [OFF_W-1:0] off_q, off_d;
  logic             skip_q, skip_d;
  logic             w_eoe, w_term, w_empty, take;

  assign w_eoe       = rd_word_i[BIT_EOE];
  assign w_term      = rd_word_i[BIT_TERM];
  assign w_empty     = rd_word_i[BIT_EMPTY];
  assign take        = (st_q == RD_CHECK) && (skip_q || !out_full_i);
  assign rd_addr_o   = {buf_q, off_q};
  assign push_word_o = rd_word_i;
  assign busy_o      = (st_q != RD_IDLE);

  always_comb begin
    st_d       = st_q;
    buf_d      = buf_q;
    off_d      = off_q;
    skip_d     = skip_q;
    trig_pop_o = 1'b0;
    push_o     = 1'b0;
    case (st_q)
      RD_IDLE: begin
        if (tx_en_i && !trig_empty_i) begin
          trig_pop_o = 1'b1;
          buf_d      = trig_buf_i;
          skip_d     = 1'b0;
          st_d       = RD_FETCH;
        end
      end
      RD_FETCH: st_d = RD_CHECK;
      RD_CHECK: begin
        if (take) begin
          push_o = !skip_q;
          off_d  = (w_eoe && w_term) ? '0 : off_q + OFF_W'(1);
          if (w_eoe) begin
            skip_d = 1'b0;
            st_d   = RD_IDLE;
          end else begin
            if (w_empty) skip_d = 1'b1;
            st_d = RD_FETCH;
          end
        end
      end
      default: st_d = RD_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= RD_IDLE;
      buf_q  <= '0;
      off_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      buf_q  <= buf_d;
      off_q  <= off_d;
      skip_q <= skip_d;
    end
  end

  // R9
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> !out_full_i);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RD_CHECK && out_full_i && !skip_q) |=> (st_q == RD_CHECK) && $stable(off_q));

  // R7
  rewind_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push_o && push_word_o[BIT_EOE] && push_word_o[BIT_TERM]) |=> (off_q == '0));

  // R4
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_pop_o |=> (st_q == RD_FETCH) && $past(!trig_empty_i));
endmodule

// File: rtl/evtpat_seq.sv
module evtpat_seq
  import evtpat_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int BUF_W      = 2,
  parameter int TRIG_DEPTH = 4,
  parameter int OUT_DEPTH  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        trig_valid,
  input  logic [1:0]  trig_buf,
  input  logic        host_op_valid,
  input  logic [1:0]  host_op,
  input  logic [27:0] host_wdata,
  output logic [27:0] host_rdata,
  input  logic        en_we,
  input  logic        en_wdata,
  output logic        tx_en,
  input  logic        out_rd,
  output logic        out_valid,
  output logic [27:0] out_word
);
  logic [1:0]        rst_sync_q;
  logic              srst_n;
  logic              tx_en_q, tx_en_d;
  logic              trig_push, trig_pop, trig_empty, trig_full;
  logic [BUF_W-1:0]  trig_head;
  logic [ADDR_W-1:0] rdr_addr;
  logic [WORD_W-1:0] rd_word, push_word;
  logic              push, out_full, out_empty, rdr_busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign srst_n = rst_sync_q[1];

  always_comb tx_en_d = en_we ? en_wdata : tx_en_q;

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) tx_en_q <= 1'b0;
    else         tx_en_q <= tx_en_d;
  end

  assign tx_en     = tx_en_q;
  assign trig_push = trig_valid && tx_en_q;
  assign out_valid = !out_empty;

  evtpat_fifo #(.W(BUF_W), .DEPTH(TRIG_DEPTH)) u_trig_q (
    .clk(clk), .rst_n(srst_n),
    .wr_en_i(trig_push), .wr_data_i(trig_buf[BUF_W-1:0]),
    .rd_en_i(trig_pop), .rd_data_o(trig_head),
    .empty_o(trig_empty), .full_o(trig_full)
  );

  evtpat_mem #(.ADDR_W(ADDR_W)) u_mem (
    .clk(clk), .rst_n(srst_n),
    .host_op_valid_i(host_op_valid), .host_op_i(host_op),
    .host_wdata_i(host_wdata),
    .rd_owner_i(tx_en_q || rdr_busy), .rdr_addr_i(rdr_addr),
    .rd_word_o(rd_word), .host_rdata_o(host_rdata)
  );

  evtpat_reader #(.ADDR_W(ADDR_W), .BUF_W(BUF_W)) u_rdr (
    .clk(clk), .rst_n(srst_n),
    .tx_en_i(tx_en_q), .trig_empty_i(trig_empty), .trig_buf_i(trig_head),
    .trig_pop_o(trig_pop), .rd_addr_o(rdr_addr), .rd_word_i(rd_word),
    .out_full_i(out_full), .push_o(push), .push_word_o(push_word),
    .busy_o(rdr_busy)
  );

  evtpat_fifo #(.W(WORD_W), .DEPTH(OUT_DEPTH)) u_out_q (
    .clk(clk), .rst_n(srst_n),
    .wr_en_i(push), .wr_data_i(push_word),
    .rd_en_i(out_rd), .rd_data_o(out_word),
    .empty_o(out_empty), .full_o(out_full)
  );

  // R4
  no_queue_when_off_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (!tx_en_q && trig_empty && !rdr_busy) |=> !u_out_q.do_wr);

  // R4
  trig_full_drop_chk: assert property (@(posedge clk) disable iff (!srst_n)
    (trig_full && !trig_pop) |=> trig_full);
endmodule

// File: tb/evtpat_seq_tb.sv
module evtpat_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        trig_valid;
  logic [1:0]  trig_buf;
  logic        host_op_valid;
  logic [1:0]  host_op;
  logic [27:0] host_wdata;
  logic [27:0] host_rdata;
  logic        en_we, en_wdata, tx_en;
  logic        out_rd, out_valid;
  logic [27:0] out_word;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;
  int off_m  = 0;
  logic [27:0] exp_q [256];
  int exp_wr = 0;
  int exp_rd = 0;

  // buffer number, expected word count per trigger
  localparam int TAB [10][2] = '{'{0,4}, '{1,2}, '{3,1}, '{2,2}, '{0,4},
                                 '{3,2}, '{1,4}, '{1,2}, '{2,4}, '{0,2}};

  always #2 clk = ~clk;

  evtpat_seq u_dut (
    .clk(clk), .rst_n(rst_n), .trig_valid(trig_valid), .trig_buf(trig_buf),
    .host_op_valid(host_op_valid), .host_op(host_op), .host_wdata(host_wdata),
    .host_rdata(host_rdata), .en_we(en_we), .en_wdata(en_wdata), .tx_en(tx_en),
    .out_rd(out_rd), .out_valid(out_valid), .out_word(out_word)
  );

  function automatic logic [27:0] pat(input int b, input int off);
    logic [22:0] d;
    d = 23'h100000 | 23'(b * 256 + off);
    case (off)
      0:       pat = (b == 3) ? {5'b00100, 23'(b)} : {5'b00001, 23'(5 + b)};
      1:       pat = {5'b00000, d};
      2:       pat = {5'b00010, 23'(7)};
      3:       pat = {5'b01000, d};
      4:       pat = {5'b00001, 23'(9)};
      5:       pat = {5'b11000, d};
      default: pat = '0;
    endcase
  endfunction

  task automatic chk(input string req, input logic [27:0] act, input logic [27:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic host_do(input logic [1:0] op, input logic [27:0] d);
    @(negedge clk);
    host_op_valid = 1'b1; host_op = op; host_wdata = d;
    @(negedge clk);
    host_op_valid = 1'b0;
  endtask

  task automatic host_rep(input logic [1:0] op, input int n);
    @(negedge clk);
    host_op_valid = 1'b1; host_op = op;
    repeat (n) @(negedge clk);
    host_op_valid = 1'b0;
  endtask

  task automatic set_en(input logic v);
    @(negedge clk);
    en_we = 1'b1; en_wdata = v;
    @(negedge clk);
    en_we = 1'b0;
  endtask

  task automatic add_event(input int b);
    int i;
    bit skip;
    logic [27:0] w;
    i = off_m;
    skip = 1'b0;
    for (int k = 0; k < 16; k++) begin
      w = pat(b, i);
      if (!skip) begin
        exp_q[exp_wr] = w;
        exp_wr++;
      end
      if (w[26]) begin
        i = w[27] ? 0 : i + 1;
        break;
      end
      if (w[25]) skip = 1'b1;
      i++;
    end
    off_m = i;
  endtask

  task automatic drain(input int n, input string req);
    int got;
    got = 0;
    for (int c = 0; c < 400 && got < n; c++) begin
      @(negedge clk);
      if (out_valid) begin
        chk(req, out_word, exp_q[exp_rd]);
        exp_rd++;
        got++;
        out_rd = 1'b1;
      end else begin
        out_rd = 1'b0;
      end
    end
    @(negedge clk);
    out_rd = 1'b0;
    chk({req, " count"}, 28'(got), 28'(n));
    repeat (10) @(negedge clk);
    chk("R9 R10 no extra word", 28'(out_valid), 28'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [27:0] held;
    rst_n = 1'b0; trig_valid = 1'b0; trig_buf = '0;
    host_op_valid = 1'b0; host_op = '0; host_wdata = '0;
    en_we = 1'b0; en_wdata = 1'b0; out_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    chk("R1 tx_en", 28'(tx_en), 28'd0);
    chk("R1 R10 out_valid", 28'(out_valid), 28'd0);
    chk("R1 host_rdata", host_rdata, 28'd0);

    // R2 load buffers via write and advance
    host_do(2'd1, '0);
    for (int b = 0; b < 4; b++) begin
      @(negedge clk);
      host_op_valid = 1'b1; host_op = 2'd0;
      for (int o = 0; o < 6; o++) begin
        host_wdata = pat(b, o);
        @(negedge clk);
      end
      host_op_valid = 1'b0;
      if (b < 3) host_rep(2'd2, 1018);
    end

    // R3 readback while disabled
    host_do(2'd1, '0);
    host_do(2'd3, '0);
    @(negedge clk);
    chk("R3 readback word0", host_rdata, pat(0, 0));
    host_do(2'd2, '0);
    host_do(2'd3, '0);
    @(negedge clk);
    chk("R2 R3 readback after advance", host_rdata, pat(0, 1));
    host_do(2'd1, '0);
    host_rep(2'd2, 1029);
    host_do(2'd3, '0);
    @(negedge clk);
    chk("R2 write auto-increment into buffer 1", host_rdata, pat(1, 5));

    // R4 trigger while disabled is dropped
    @(negedge clk); trig_valid = 1'b1; trig_buf = 2'd2;
    @(negedge clk); trig_valid = 1'b0;
    set_en(1'b1);
    chk("R1 R4 tx_en after host write", 28'(tx_en), 28'd1);
    repeat (20) @(negedge clk);
    chk("R4 dropped trigger gives no output", 28'(out_valid), 28'd0);

    // R3 read op while enabled leaves host_rdata unchanged
    held = host_rdata;
    host_do(2'd3, '0);
    repeat (3) @(negedge clk);
    chk("R3 read ignored while enabled", host_rdata, held);

    // R5 R6 R7 R8 table walk
    for (int t = 0; t < 10; t++) begin
      @(negedge clk); trig_valid = 1'b1; trig_buf = 2'(TAB[t][0]);
      @(negedge clk); trig_valid = 1'b0;
      add_event(TAB[t][0]);
      repeat (30) @(negedge clk);
      if (TAB[t][1] == 1) drain(TAB[t][1], "R8 empty event");
      else                drain(TAB[t][1], "R5 R6 R7 event word");
    end

    // R9 stall on full output FIFO, then drain with concurrent refill
    @(negedge clk); trig_valid = 1'b1; trig_buf = 2'd0; add_event(0);
    @(negedge clk); trig_buf = 2'd0; add_event(0);
    @(negedge clk); trig_buf = 2'd2; add_event(2);
    @(negedge clk); trig_buf = 2'd2; add_event(2);
    @(negedge clk); trig_valid = 1'b0;
    repeat (100) @(negedge clk);
    chk("R9 R10 full FIFO holds data", 28'(out_valid), 28'd1);
    drain(12, "R9 stalled stream");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule